// File: doc/BRIEF.md
# General-Purpose Result Rename Register File

This block holds speculative integer results in a small pool of tagged temporary registers until they are retired. At dispatch the front end asks for a rename register for an instruction's destination and gets back a tag. The execution unit later writes its result into the register that the tag names. Instructions that read a register look it up by architected number. They get either a finished value, or the tag they must wait on together with a not-ready flag.

At retirement the finished value is copied into the 32-entry architected register file and the temporary register goes back to the pool. A flush discards every result that has not retired, so squashed work never reaches architected state. The block has a parameterised number of lookup ports and one port for reading the architected file.

Top module: `rename_regfile`

## Requirements
- R1: After reset every rename register is free, `free_cnt` equals NUM_REN, `full` is low, and every architected register reads 0.
- R2: When `alloc_req` is high and `flush` is low and a register is free, `alloc_ok` goes high in the same cycle. `alloc_tag` is the lowest-numbered free register, and `free_cnt` is one lower in the next cycle, unless a retire happens in the same cycle.
- R3: `full` is high exactly when `free_cnt` is 0, and while `full` is high `alloc_ok` stays low.
- R4: A lookup of an architected register whose newest rename register has no result yet returns `src_pend`=1, `src_rdy`=0 and `src_tag` equal to that register's tag.
- R5: A result write to an allocated tag is stored and seen as ready by later lookups. A lookup in the same cycle as the write to its pending tag sees the written value with `src_rdy`=1. Writes to a free tag are ignored.
- R6: When several rename registers are mapped to one architected register, a lookup uses the one allocated most recently.
- R7: A lookup of an architected register with no live mapping returns the architected value with `src_rdy`=1 and `src_pend`=0. A lookup in the same cycle as an allocation sees the state before that allocation.
- R8: Retiring a tag whose result has been written copies the value into its architected register and frees the tag in the next cycle. Retiring a tag that is free or has no result yet changes nothing.
- R9: `flush` frees every rename register and clears every mapping in the next cycle. In its own cycle it blocks allocation, result writes and retirement, and it leaves the architected registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request a rename register for a destination |
| alloc_areg | input | AREG_W | Architected destination of the allocation |
| alloc_ok | output | 1 | Allocation granted this cycle |
| alloc_tag | output | TAG_W | Tag of the granted rename register |
| full | output | 1 | No rename register is free |
| free_cnt | output | CNT_W | Number of free rename registers |
| wr_en | input | 1 | Result write valid |
| wr_tag | input | TAG_W | Tag the result is written to |
| wr_data | input | DATA_W | Result value |
| src_areg | input | NUM_SRC*AREG_W | Architected registers looked up, source k in slice k |
| src_val | output | NUM_SRC*DATA_W | Operand values |
| src_rdy | output | NUM_SRC | Operand value is valid |
| src_pend | output | NUM_SRC | Operand is mapped to a rename register |
| src_tag | output | NUM_SRC*TAG_W | Tag the operand waits on |
| retire_en | input | 1 | Retire request |
| retire_tag | input | TAG_W | Tag being retired |
| flush | input | 1 | Discard all unretired results |
| arch_rd_addr | input | AREG_W | Architected register read address |
| arch_rd_data | output | DATA_W | Architected register contents |

## Verification
The bench builds the block with its defaults: six rename registers, 32 architected registers of 32 bits, and two lookup ports. With only six tags, the pool fills after six allocations, so the full condition, the refused grant and the lowest-free tag order can all be reached within a few cycles. Two allocations to the same architected register exercise the choice of the newest mapping. The bench also covers the fall-back to the architected value once both of those mappings have retired.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Per-entry status kept for every rename register.
  typedef struct packed {
    logic busy;    // allocated, not yet retired or flushed
    logic done;    // result has been written
    logic newest;  // most recent mapping of its architected register
  } rrf_flags_t;
endpackage

// File: rtl/rrf_free_pick.sv
module rrf_free_pick #(
  parameter int N     = 6,
  parameter int TAG_W = 3,
  parameter int CNT_W = 3
) (
  input  logic [N-1:0]     busy,
  output logic             any_free,
  output logic [TAG_W-1:0] pick,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    pick     = '0;
    any_free = 1'b0;
    count    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        pick     = TAG_W'(i);
        any_free = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      count = count + CNT_W'(!busy[i]);
    end
  end
endmodule

// File: rtl/rrf_src_lookup.sv
module rrf_src_lookup #(
  parameter int N      = 6,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic [AREG_W-1:0]         src,
  input  logic [N-1:0]              busy,
  input  logic [N-1:0]              done,
  input  logic [N-1:0]              newest,
  input  logic [N-1:0][AREG_W-1:0]  areg,
  input  logic [N-1:0][DATA_W-1:0]  data,
  input  logic                      wr_en,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [DATA_W-1:0]         arch_val,
  output logic [DATA_W-1:0]         val,
  output logic                      rdy,
  output logic                      pend,
  output logic [TAG_W-1:0]          tag
);
  logic              hit;
  logic              hit_done;
  logic [DATA_W-1:0] hit_data;

  always_comb begin
    hit      = 1'b0;
    hit_done = 1'b0;
    hit_data = '0;
    tag      = '0;
    for (int i = 0; i < N; i++) begin
      if (busy[i] && newest[i] && (areg[i] == src)) begin
        hit      = 1'b1;
        hit_done = done[i];
        hit_data = data[i];
        tag      = TAG_W'(i);
      end
    end
  end

  always_comb begin
    pend = hit;
    if (!hit) begin
      val = arch_val;
      rdy = 1'b1;
    end else if (hit_done) begin
      val = hit_data;
      rdy = 1'b1;
    end else if (wr_en && (wr_tag == tag)) begin
      val = wr_data;
      rdy = 1'b1;
    end else begin
      val = '0;
      rdy = 1'b0;
    end
  end
endmodule

// File: rtl/rrf_arch_file.sv
module rrf_arch_file #(
  parameter int NUM_ARCH = 32,
  parameter int AREG_W   = 5,
  parameter int DATA_W   = 32,
  parameter int NUM_RD   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AREG_W-1:0]          waddr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NUM_RD*AREG_W-1:0]   raddr,
  output logic [NUM_RD*DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] regs_q [NUM_ARCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) regs_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        if (waddr == AREG_W'(i)) regs_q[i] <= wdata;
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic [AREG_W-1:0] a;
    logic [DATA_W-1:0] d;
    assign a = raddr[r*AREG_W +: AREG_W];
    always_comb begin
      d = '0;
      for (int i = 0; i < NUM_ARCH; i++) begin
        if (a == AREG_W'(i)) d = regs_q[i];
      end
    end
    assign rdata[r*DATA_W +: DATA_W] = d;
  end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile #(
  parameter int NUM_REN  = 6,
  parameter int NUM_ARCH = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 2,
  localparam int TAG_W   = (NUM_REN > 1) ? $clog2(NUM_REN) : 1,
  localparam int CNT_W   = $clog2(NUM_REN + 1),
  localparam int AREG_W  = $clog2(NUM_ARCH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_req,
  input  logic [AREG_W-1:0]           alloc_areg,
  output logic                        alloc_ok,
  output logic [TAG_W-1:0]            alloc_tag,
  output logic                        full,
  output logic [CNT_W-1:0]            free_cnt,
  input  logic                        wr_en,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_SRC*AREG_W-1:0]   src_areg,
  output logic [NUM_SRC*DATA_W-1:0]   src_val,
  output logic [NUM_SRC-1:0]          src_rdy,
  output logic [NUM_SRC-1:0]          src_pend,
  output logic [NUM_SRC*TAG_W-1:0]    src_tag,
  input  logic                        retire_en,
  input  logic [TAG_W-1:0]            retire_tag,
  input  logic                        flush,
  input  logic [AREG_W-1:0]           arch_rd_addr,
  output logic [DATA_W-1:0]           arch_rd_data
);
  import rrf_pkg::*;

  localparam int NUM_RD = NUM_SRC + 1;

  rrf_flags_t [NUM_REN-1:0]             flg_q, flg_d;
  logic [NUM_REN-1:0][AREG_W-1:0]       areg_q, areg_d;
  logic [NUM_REN-1:0][DATA_W-1:0]       data_q;
  logic [NUM_REN-1:0]                   busy_v, done_v, newest_v;
  logic [NUM_REN-1:0]                   wr_hit;
  logic                                 any_free;
  logic [TAG_W-1:0]                     pick;
  logic                                 ret_ok;
  logic [AREG_W-1:0]                    ret_areg;
  logic [DATA_W-1:0]                    ret_data;
  logic                                 state_en;
  logic [NUM_RD*AREG_W-1:0]             rd_addr;
  logic [NUM_RD*DATA_W-1:0]             rd_data;

  for (genvar i = 0; i < NUM_REN; i++) begin : g_flat
    assign busy_v[i]   = flg_q[i].busy;
    assign done_v[i]   = flg_q[i].done;
    assign newest_v[i] = flg_q[i].newest;
    assign wr_hit[i]   = !flush && wr_en && (wr_tag == TAG_W'(i)) &&
                         flg_q[i].busy && !flg_q[i].done;
  end

  rrf_free_pick #(.N(NUM_REN), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pick (
    .busy     (busy_v),
    .any_free (any_free),
    .pick     (pick),
    .count    (free_cnt)
  );

  assign full      = !any_free;
  assign alloc_ok  = alloc_req && any_free && !flush;
  assign alloc_tag = pick;

  // Retire qualification: the tag must be live and its result written.
  always_comb begin
    ret_ok   = 1'b0;
    ret_areg = '0;
    ret_data = '0;
    for (int i = 0; i < NUM_REN; i++) begin
      if (retire_en && !flush && (retire_tag == TAG_W'(i)) &&
          flg_q[i].busy && flg_q[i].done) begin
        ret_ok   = 1'b1;
        ret_areg = areg_q[i];
        ret_data = data_q[i];
      end
    end
  end

  // Next state of the entry flags and mappings.
  always_comb begin
    flg_d  = flg_q;
    areg_d = areg_q;
    if (flush) begin
      flg_d = '0;
    end else begin
      for (int i = 0; i < NUM_REN; i++) begin
        if (wr_hit[i]) flg_d[i].done = 1'b1;
        if (ret_ok && (retire_tag == TAG_W'(i))) flg_d[i] = '0;
        if (alloc_ok && flg_q[i].busy && (areg_q[i] == alloc_areg))
          flg_d[i].newest = 1'b0;
      end
      if (alloc_ok) begin
        for (int i = 0; i < NUM_REN; i++) begin
          if (pick == TAG_W'(i)) begin
            flg_d[i].busy   = 1'b1;
            flg_d[i].done   = 1'b0;
            flg_d[i].newest = 1'b1;
            areg_d[i]       = alloc_areg;
          end
        end
      end
    end
  end

  assign state_en = flush || alloc_ok || ret_ok || (|wr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q  <= '0;
      areg_q <= '0;
    end else if (state_en) begin
      flg_q  <= flg_d;
      areg_q <= areg_d;
    end
  end

  // Result storage needs no reset: it is read only when the done flag is set.
  for (genvar i = 0; i < NUM_REN; i++) begin : g_data
    always_ff @(posedge clk) begin
      if (wr_hit[i]) data_q[i] <= wr_data;
    end
  end

  assign rd_addr = {arch_rd_addr, src_areg};

  rrf_arch_file #(
    .NUM_ARCH (NUM_ARCH),
    .AREG_W   (AREG_W),
    .DATA_W   (DATA_W),
    .NUM_RD   (NUM_RD)
  ) u_arch (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ret_ok),
    .waddr (ret_areg),
    .wdata (ret_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign arch_rd_data = rd_data[NUM_SRC*DATA_W +: DATA_W];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rrf_src_lookup #(
      .N      (NUM_REN),
      .AREG_W (AREG_W),
      .DATA_W (DATA_W),
      .TAG_W  (TAG_W)
    ) u_lkp (
      .src      (src_areg[s*AREG_W +: AREG_W]),
      .busy     (busy_v),
      .done     (done_v),
      .newest   (newest_v),
      .areg     (areg_q),
      .data     (data_q),
      .wr_en    (wr_en && !flush),
      .wr_tag   (wr_tag),
      .wr_data  (wr_data),
      .arch_val (rd_data[s*DATA_W +: DATA_W]),
      .val      (src_val[s*DATA_W +: DATA_W]),
      .rdy      (src_rdy[s]),
      .pend     (src_pend[s]),
      .tag      (src_tag[s*TAG_W +: TAG_W])
    );
  end
endmodule

// File: rtl/rrf_chk.sv
module rrf_chk #(
  parameter int NUM_REN = 6,
  parameter int TAG_W   = 3,
  parameter int CNT_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ok,
  input logic             full,
  input logic [CNT_W-1:0] free_cnt,
  input logic             retire_en,
  input logic             flush,
  input logic             wr_en,
  input logic [TAG_W-1:0] wr_tag,
  input logic             src_pend0,
  input logic             src_rdy0,
  input logic [TAG_W-1:0] src_tag0
);
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(NUM_REN));

  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ok);

  a_r2_alloc_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && !retire_en && !flush) |=> (free_cnt == $past(free_cnt) - 1'b1));

  a_r9_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_cnt == CNT_W'(NUM_REN)) && !full);

  a_r5_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && src_pend0 && (src_tag0 == wr_tag)) |-> src_rdy0);

  a_r7_arch_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pend0 |-> src_rdy0);
endmodule

bind rename_regfile rrf_chk #(
  .NUM_REN (NUM_REN),
  .TAG_W   (TAG_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alloc_ok  (alloc_ok),
  .full      (full),
  .free_cnt  (free_cnt),
  .retire_en (retire_en),
  .flush     (flush),
  .wr_en     (wr_en),
  .wr_tag    (wr_tag),
  .src_pend0 (src_pend[0]),
  .src_rdy0  (src_rdy[0]),
  .src_tag0  (src_tag[TAG_W-1:0])
);

// File: tb/rename_regfile_tb.sv
module rename_regfile_tb;
  localparam int NREN = 6;
  localparam int DW   = 32;
  localparam int AW   = 5;
  localparam int TW   = 3;
  localparam int CW   = 3;

  logic          clk, rst_n;
  logic          alloc_req;
  logic [AW-1:0] alloc_areg;
  logic          alloc_ok;
  logic [TW-1:0] alloc_tag;
  logic          full;
  logic [CW-1:0] free_cnt;
  logic          wr_en;
  logic [TW-1:0] wr_tag;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] s0, s1;
  logic [2*DW-1:0] src_val;
  logic [1:0]    src_rdy, src_pend;
  logic [2*TW-1:0] src_tag;
  logic          retire_en;
  logic [TW-1:0] retire_tag;
  logic          flush;
  logic [AW-1:0] arch_rd_addr;
  logic [DW-1:0] arch_rd_data;

  rename_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_areg(alloc_areg), .alloc_ok(alloc_ok),
    .alloc_tag(alloc_tag), .full(full), .free_cnt(free_cnt),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_data(wr_data),
    .src_areg({s1, s0}), .src_val(src_val), .src_rdy(src_rdy),
    .src_pend(src_pend), .src_tag(src_tag),
    .retire_en(retire_en), .retire_tag(retire_tag), .flush(flush),
    .arch_rd_addr(arch_rd_addr), .arch_rd_data(arch_rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef enum int {
    K_OK, K_TAG, K_FREE, K_FULL, K_V0, K_R0, K_P0, K_T0, K_ARCH, K_V1, K_R1
  } kind_t;

  typedef struct {
    kind_t       kind;
    string       req;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  event  chk_ev;

  function automatic logic [31:0] actual(kind_t k);
    case (k)
      K_OK:   return 32'(alloc_ok);
      K_TAG:  return 32'(alloc_tag);
      K_FREE: return 32'(free_cnt);
      K_FULL: return 32'(full);
      K_V0:   return src_val[DW-1:0];
      K_R0:   return 32'(src_rdy[0]);
      K_P0:   return 32'(src_pend[0]);
      K_T0:   return 32'(src_tag[TW-1:0]);
      K_ARCH: return arch_rd_data;
      K_V1:   return src_val[2*DW-1:DW];
      K_R1:   return 32'(src_rdy[1]);
      default: return 32'hdead;
    endcase
  endfunction

  // Monitor: pops every queued expectation when the driver signals a sample point.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (actual(it.kind) !== it.exp) begin
          bad++;
          $display("FAIL %s %s: actual=%h expected=%h", it.req, it.kind.name(),
                   actual(it.kind), it.exp);
        end
      end
    end
  end

  task automatic expect_v(kind_t k, string req, logic [31:0] e);
    item_t it;
    it.kind = k; it.req = req; it.exp = e;
    q.push_back(it);
  endtask

  task automatic sample();
    #4;
    -> chk_ev;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    alloc_req = 0; wr_en = 0; retire_en = 0; flush = 0;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; alloc_req = 0; alloc_areg = 0; wr_en = 0; wr_tag = 0; wr_data = 0;
    s0 = 0; s1 = 0; retire_en = 0; retire_tag = 0; flush = 0; arch_rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    s0 = 5; arch_rd_addr = 5;
    sample();
    expect_v(K_FREE, "R1", NREN); expect_v(K_FULL, "R1", 0);
    expect_v(K_ARCH, "R1", 0); expect_v(K_OK, "R1", 0);
    expect_v(K_V0, "R7", 0); expect_v(K_R0, "R7", 1); expect_v(K_P0, "R7", 0);
    sample();

    // R2 allocate r3, lookup in same cycle sees old state (R7)
    next_cycle(); alloc_req = 1; alloc_areg = 3; s0 = 3;
    expect_v(K_OK, "R2", 1); expect_v(K_TAG, "R2", 0); expect_v(K_P0, "R7", 0);
    sample();
    next_cycle();
    expect_v(K_FREE, "R2", NREN - 1); expect_v(K_P0, "R4", 1);
    expect_v(K_R0, "R4", 0); expect_v(K_T0, "R4", 0);
    sample();

    // R5 forward then stored
    next_cycle(); wr_en = 1; wr_tag = 0; wr_data = 32'hAAAA;
    expect_v(K_R0, "R5", 1); expect_v(K_V0, "R5", 32'hAAAA);
    sample();
    next_cycle();
    expect_v(K_R0, "R5", 1); expect_v(K_V0, "R5", 32'hAAAA);
    sample();

    // R6 second mapping of r3 wins
    next_cycle(); alloc_req = 1; alloc_areg = 3;
    expect_v(K_TAG, "R2", 1);
    sample();
    next_cycle();
    expect_v(K_T0, "R6", 1); expect_v(K_R0, "R6", 0); expect_v(K_P0, "R6", 1);
    sample();
    next_cycle(); wr_en = 1; wr_tag = 1; wr_data = 32'hBBBB;
    sample();
    next_cycle();
    expect_v(K_V0, "R6", 32'hBBBB); expect_v(K_R0, "R6", 1);
    sample();

    // R8 retire older then newer
    next_cycle(); retire_en = 1; retire_tag = 0; arch_rd_addr = 3;
    sample();
    next_cycle();
    expect_v(K_ARCH, "R8", 32'hAAAA); expect_v(K_V0, "R6", 32'hBBBB);
    expect_v(K_P0, "R6", 1); expect_v(K_FREE, "R8", NREN - 1);
    sample();
    next_cycle(); retire_en = 1; retire_tag = 1;
    sample();
    next_cycle();
    expect_v(K_ARCH, "R8", 32'hBBBB); expect_v(K_P0, "R7", 0);
    expect_v(K_R0, "R7", 1); expect_v(K_V0, "R7", 32'hBBBB);
    expect_v(K_FREE, "R8", NREN);
    sample();

    // R8 retire of an unwritten tag is ignored; R5 write to a free tag ignored
    next_cycle(); alloc_req = 1; alloc_areg = 4; wr_en = 1; wr_tag = 4; wr_data = 32'h77;
    expect_v(K_TAG, "R2", 0);
    sample();
    next_cycle(); retire_en = 1; retire_tag = 0; arch_rd_addr = 4;
    sample();
    next_cycle(); retire_en = 1; retire_tag = 4;
    expect_v(K_FREE, "R8", NREN - 1); expect_v(K_ARCH, "R8", 0);
    sample();
    next_cycle(); wr_en = 1; wr_tag = 0; wr_data = 32'h44;
    expect_v(K_FREE, "R5", NREN - 1); expect_v(K_ARCH, "R5", 0);
    sample();
    next_cycle(); retire_en = 1; retire_tag = 0;
    sample();
    next_cycle(); s1 = 4;
    expect_v(K_ARCH, "R8", 32'h44); expect_v(K_FREE, "R8", NREN);
    expect_v(K_V1, "R7", 32'h44); expect_v(K_R1, "R7", 1);
    sample();

    // R3 fill the pool in lowest-free order
    for (int k = 0; k < NREN; k++) begin
      next_cycle(); alloc_req = 1; alloc_areg = AW'(7 + k);
      expect_v(K_OK, "R2", 1); expect_v(K_TAG, "R2", k);
      sample();
    end
    next_cycle(); alloc_req = 1; alloc_areg = 20;
    expect_v(K_FULL, "R3", 1); expect_v(K_FREE, "R3", 0); expect_v(K_OK, "R3", 0);
    sample();

    // R9 flush discards results and mappings
    next_cycle(); wr_en = 1; wr_tag = 2; wr_data = 32'h1234; s0 = 9;
    sample();
    next_cycle(); s0 = 9; arch_rd_addr = 9;
    expect_v(K_V0, "R5", 32'h1234); expect_v(K_R0, "R5", 1);
    sample();
    next_cycle(); flush = 1; alloc_req = 1; alloc_areg = 9; retire_en = 1; retire_tag = 2;
    expect_v(K_OK, "R9", 0);
    sample();
    next_cycle();
    expect_v(K_FREE, "R9", NREN); expect_v(K_FULL, "R9", 0);
    expect_v(K_P0, "R9", 0); expect_v(K_V0, "R9", 0); expect_v(K_ARCH, "R9", 0);
    sample();
    next_cycle(); retire_en = 1; retire_tag = 2;
    sample();
    next_cycle();
    expect_v(K_ARCH, "R9", 0); expect_v(K_FREE, "R9", NREN);
    sample();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule